// File: doc/BRIEF.md
# Audio Sample FIFO with Quartile Level Report

This block is an eight-deep, 32-bit sample queue that sits between a bus or DMA side and a serial audio engine. One direction input chooses how it is used. In transmit, the bus side pushes samples and the engine pops them. In receive, the engine pushes captured samples and the bus side pops them. Besides the full and empty flags, the block reports how full it is as a coarse quartile code. It also raises a service request against a selectable quartile threshold. In transmit the request asks for more data; in receive it asks for data to be drained.

Occupancy is tracked by a three-state machine. The states are OCC_EMPTY, OCC_PARTIAL and OCC_FULL.
- An accepted push moves OCC_EMPTY to OCC_PARTIAL ("first word").
- An accepted push without a pop, made when one slot is free, moves OCC_PARTIAL to OCC_FULL ("last slot taken").
- An accepted pop without a push, made when one word is held, moves OCC_PARTIAL to OCC_EMPTY ("last word gone").
- An accepted pop moves OCC_FULL to OCC_PARTIAL ("slot freed").
- A flush moves any state to OCC_EMPTY.

A single sticky error flag records a push into a full queue while receiving (overrun) and a pop from an empty queue while transmitting (underrun). Software clears it by pulsing a clear input.

Top module: `audio_sample_fifo`

## Requirements
- R1: Reset brings the block to this state: empty high, full low, level code 000 and error flag low. The queue is empty afterwards.
- R2: A push is accepted only while full is low. Words leave in the order they were accepted. pop_data always shows the oldest held word. full is high exactly when 8 words are held, and full and empty are never high together.
- R3: A pop removes a word only while empty is high low, that is, only while the queue holds a word. A push and a pop accepted in the same cycle leave the word count unchanged.
- R4: The level code depends on the held count n (depth 8):
  - 000 when n = 0
  - 001 when n is 1 or 2
  - 010 when n is 3 or 4
  - 011 when n is 5 or 6
  - 100 when n = 7
  - 101 when n = 8
- R5: The threshold select maps to a word count:
  - 000 gives 0
  - 001 gives 2
  - 010 gives 4
  - 011 gives 6
  - 100 gives 8
  - the unused codes 101 to 111 behave as 100.
- R6: In transmit (dir_rx = 0), svc_req is high exactly while n is at or below the threshold count. With threshold 000 this means only while empty.
- R7: In receive (dir_rx = 1), svc_req is high exactly while n is at or above the threshold count and the queue is not empty.
- R8: A flush empties the queue in the next cycle. Push and pop in the flush cycle are ignored, and the error flag is unaffected.
- R9: In receive, a push while full drops the word and sets the error flag. In transmit, the same push is dropped without setting the flag.
- R10: In transmit, a pop while empty sets the error flag. In receive, the same pop leaves the flag unchanged.
- R11: The error flag stays set until err_clear is pulsed high. If a new error and a clear occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rx | input | 1 | 0 transmit, 1 receive |
| thresh_sel | input | 3 | Request threshold select |
| flush | input | 1 | Empty the queue |
| push | input | 1 | Write request |
| push_data | input | 32 | Word to write |
| pop | input | 1 | Read request |
| pop_data | output | 32 | Oldest held word |
| full | output | 1 | Queue holds 8 words |
| empty | output | 1 | Queue holds no word |
| level_code | output | 3 | Quartile fill code |
| svc_req | output | 1 | Service request |
| err_flag | output | 1 | Sticky overrun/underrun flag |
| err_clear | input | 1 | Clears err_flag |

## Verification
The properties assume that push, pop, flush and err_clear are sampled as plain levels on each clock. They also assume that dir_rx and thresh_sel may change in any cycle, because both feed the request without registers. The stimulus changes every input once per cycle, away from the active edge, and keeps the held count inside 0 to 8 as the design defines it. Error cases are driven on purpose only in the direction where they should count. The same stimulus is then repeated in the other direction to show that it is ignored there.

// File: rtl/asf_pkg.sv
package asf_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    typedef enum logic [2:0] {
        LVL_NONE = 3'd0,
        LVL_Q1   = 3'd1,
        LVL_Q2   = 3'd2,
        LVL_Q3   = 3'd3,
        LVL_HIGH = 3'd4,
        LVL_TOP  = 3'd5
    } lvl_code_e;
endpackage

// File: rtl/asf_store.sv
module asf_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            count_q <= count_q + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign rd_data = mem[rd_ptr];
    assign count   = count_q;
endmodule

// File: rtl/asf_grader.sv
module asf_grader
    import asf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [2:0]    thresh_sel,
    input  logic          dir_rx,
    output logic [2:0]    level_code,
    output logic          svc_req
);
    localparam logic [CW-1:0] QUART1 = CW'(DEPTH / 4);
    localparam logic [CW-1:0] QUART2 = CW'(DEPTH / 2);
    localparam logic [CW-1:0] QUART3 = CW'((3 * DEPTH) / 4);
    localparam logic [CW-1:0] ALL    = CW'(DEPTH);

    lvl_code_e     lvl;
    logic [CW-1:0] thr_cnt;

    always_comb begin
        if (count == '0)          lvl = LVL_NONE;
        else if (count <= QUART1) lvl = LVL_Q1;
        else if (count <= QUART2) lvl = LVL_Q2;
        else if (count <= QUART3) lvl = LVL_Q3;
        else if (count <  ALL)    lvl = LVL_HIGH;
        else                      lvl = LVL_TOP;
    end

    always_comb begin
        unique case (thresh_sel)
            3'd0:    thr_cnt = '0;
            3'd1:    thr_cnt = QUART1;
            3'd2:    thr_cnt = QUART2;
            3'd3:    thr_cnt = QUART3;
            default: thr_cnt = ALL;
        endcase
    end

    always_comb begin
        if (dir_rx) svc_req = (count >= thr_cnt) && (count != '0);
        else        svc_req = (count <= thr_cnt);
    end

    assign level_code = lvl;
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import asf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_rx,
    input  logic [2:0]       thresh_sel,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             full,
    output logic             empty,
    output logic [2:0]       level_code,
    output logic             svc_req,
    output logic             err_flag,
    input  logic             err_clear
);
    occ_state_e    state_q, state_d;
    logic [CW-1:0] cnt;
    logic          wr_acc, rd_acc;
    logic          overrun, underrun;
    logic          err_q;

    // Handshake qualification; flush overrides both sides.
    assign wr_acc   = push && !full  && !flush;
    assign rd_acc   = pop  && !empty && !flush;
    assign overrun  = dir_rx  && push && full  && !flush;
    assign underrun = !dir_rx && pop  && empty && !flush;

    asf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_acc),
        .wr_data (push_data),
        .rd_en   (rd_acc),
        .rd_data (pop_data),
        .count   (cnt)
    );

    asf_grader #(.DEPTH(DEPTH)) u_grader (
        .count      (cnt),
        .thresh_sel (thresh_sel),
        .dir_rx     (dir_rx),
        .level_code (level_code),
        .svc_req    (svc_req)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = OCC_EMPTY;
        end else begin
            unique case (state_q)
                OCC_EMPTY: begin
                    if (wr_acc) state_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end
                OCC_PARTIAL: begin
                    if (wr_acc && !rd_acc && cnt == CW'(DEPTH - 1))
                        state_d = OCC_FULL;
                    else if (rd_acc && !wr_acc && cnt == CW'(1))
                        state_d = OCC_EMPTY;
                end
                OCC_FULL: begin
                    if (rd_acc) state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                end
                default: state_d = OCC_EMPTY;
            endcase
        end
    end

    // Outputs from state
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    full  = 1'b1;
            default:     empty = 1'b1;
        endcase
    end

    // Sticky error: a new error wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   err_q <= 1'b0;
        else if (overrun || underrun) err_q <= 1'b1;
        else if (err_clear)           err_q <= 1'b0;
    end

    assign err_flag = err_q;
endmodule

// File: rtl/asf_checker.sv
module asf_checker #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_rx,
    input logic          flush,
    input logic          push,
    input logic          pop,
    input logic          err_clear,
    input logic          full,
    input logic          empty,
    input logic [2:0]    level_code,
    input logic          svc_req,
    input logic          err_flag,
    input logic [CW-1:0] cnt
);
    assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop && !flush |=> full);

    assert_empty_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        empty && !push |=> empty);

    assert_level_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (level_code == 3'd0));

    assert_level_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full == (level_code == 3'd5));

    assert_tx_req_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_rx && empty |-> svc_req);

    assert_rx_noreq_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rx && empty |-> !svc_req);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rx && push && full && !flush |=> err_flag);

    assert_underrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_rx && pop && empty && !flush |=> err_flag);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clear |=> err_flag);

    assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear && !(dir_rx && push && full && !flush)
                  && !(!dir_rx && pop && empty && !flush) |=> !err_flag);
endmodule

bind audio_sample_fifo asf_checker #(.DEPTH(DEPTH)) u_asf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_rx     (dir_rx),
    .flush      (flush),
    .push       (push),
    .pop        (pop),
    .err_clear  (err_clear),
    .full       (full),
    .empty      (empty),
    .level_code (level_code),
    .svc_req    (svc_req),
    .err_flag   (err_flag),
    .cnt        (cnt)
);

// File: tb/tb_audio_sample_fifo.sv
module tb_audio_sample_fifo;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dir_rx;
    logic [2:0]  thresh_sel;
    logic        flush;
    logic        push;
    logic [31:0] push_data;
    logic        pop;
    logic [31:0] pop_data;
    logic        full, empty;
    logic [2:0]  level_code;
    logic        svc_req;
    logic        err_flag;
    logic        err_clear;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    audio_sample_fifo dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_rx     (dir_rx),
        .thresh_sel (thresh_sel),
        .flush      (flush),
        .push       (push),
        .push_data  (push_data),
        .pop        (pop),
        .pop_data   (pop_data),
        .full       (full),
        .empty      (empty),
        .level_code (level_code),
        .svc_req    (svc_req),
        .err_flag   (err_flag),
        .err_clear  (err_clear)
    );

    typedef struct packed {
        logic       push;
        logic       pop;
        logic       flush;
        logic       rx;
        logic [2:0] thr;
        logic       clr;
        logic [2:0] lvl;
        logic       req;
        logic       err;
        logic       full;
        logic       empty;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        // transmit, threshold half: fill to full (R4, R6)
        '{1'b1,1'b0,1'b0,1'b0,3'd2,1'b0, 3'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd2,1'b0, 3'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd2,1'b0, 3'd2,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd2,1'b0, 3'd2,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd2,1'b0, 3'd3,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd2,1'b0, 3'd3,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd2,1'b0, 3'd4,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,3'd2,1'b0, 3'd5,1'b0,1'b0,1'b1,1'b0},
        // transmit push while full: dropped, no error (R9)
        '{1'b1,1'b0,1'b0,1'b0,3'd2,1'b0, 3'd5,1'b0,1'b0,1'b1,1'b0},
        // pop, then push+pop keeps count (R3)
        '{1'b0,1'b1,1'b0,1'b0,3'd2,1'b0, 3'd4,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,1'b0,3'd2,1'b0, 3'd4,1'b0,1'b0,1'b0,1'b0},
        // threshold full and unused code 7 (R5)
        '{1'b0,1'b0,1'b0,1'b0,3'd4,1'b0, 3'd4,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,3'd7,1'b0, 3'd4,1'b1,1'b0,1'b0,1'b0},
        // receive thresholds (R7)
        '{1'b0,1'b0,1'b0,1'b1,3'd3,1'b0, 3'd4,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd4,1'b0, 3'd4,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1,3'd4,1'b0, 3'd5,1'b1,1'b0,1'b1,1'b0},
        // overrun (R9), clear (R11)
        '{1'b1,1'b0,1'b0,1'b1,3'd4,1'b0, 3'd5,1'b1,1'b1,1'b1,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,3'd4,1'b1, 3'd5,1'b1,1'b0,1'b1,1'b0},
        // flush (R8)
        '{1'b0,1'b0,1'b1,1'b1,3'd4,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b1},
        // receive pop while empty: no error (R10)
        '{1'b0,1'b1,1'b0,1'b1,3'd4,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b0,1'b1,3'd0,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b1},
        '{1'b1,1'b0,1'b0,1'b1,3'd0,1'b0, 3'd1,1'b1,1'b0,1'b0,1'b0},
        // transmit empty threshold only when empty (R6)
        '{1'b0,1'b0,1'b0,1'b0,3'd0,1'b0, 3'd1,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,1'b0,3'd0,1'b0, 3'd0,1'b1,1'b0,1'b0,1'b1},
        // underrun (R10), set wins over clear, then clear (R11)
        '{1'b0,1'b1,1'b0,1'b0,3'd0,1'b0, 3'd0,1'b1,1'b1,1'b0,1'b1},
        '{1'b0,1'b1,1'b0,1'b0,3'd0,1'b1, 3'd0,1'b1,1'b1,1'b0,1'b1},
        '{1'b0,1'b0,1'b0,1'b0,3'd0,1'b1, 3'd0,1'b1,1'b0,1'b0,1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        push = 1'b0; pop = 1'b0; flush = 1'b0; err_clear = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; dir_rx = 1'b0; thresh_sel = 3'd2; push_data = '0;
        idle();
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 level", 32'(level_code), 32'd0);
        chk("R1 err", 32'(err_flag), 32'd0);

        for (int i = 0; i < NV; i++) begin
            push = VEC[i].push; pop = VEC[i].pop; flush = VEC[i].flush;
            dir_rx = VEC[i].rx; thresh_sel = VEC[i].thr; err_clear = VEC[i].clr;
            push_data = 32'hC0DE_0000 + 32'(i);
            tick();
            chk("R4 level", 32'(level_code), 32'(VEC[i].lvl));
            chk(VEC[i].rx ? "R7 request" : "R6 request", 32'(svc_req), 32'(VEC[i].req));
            chk("R9 R10 R11 error", 32'(err_flag), 32'(VEC[i].err));
            chk("R2 full", 32'(full), 32'(VEC[i].full));
            chk("R3 empty", 32'(empty), 32'(VEC[i].empty));
        end
        idle();

        // R2 ordering, R9 dropped overrun word
        flush = 1'b1; tick(); flush = 1'b0;
        dir_rx = 1'b1;
        for (int i = 0; i < 8; i++) begin
            push = 1'b1; push_data = 32'h5A00_0010 + 32'(i); tick();
        end
        push_data = 32'hDEAD_BEEF; tick();
        push = 1'b0;
        chk("R9 overrun flag", 32'(err_flag), 32'd1);
        err_clear = 1'b1; tick(); err_clear = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk("R2 order", pop_data, 32'h5A00_0010 + 32'(i));
            pop = 1'b1; tick(); pop = 1'b0;
        end
        chk("R9 dropped word", 32'(empty), 32'd1);

        // R8 flush ignores push, keeps error
        dir_rx = 1'b0;
        pop = 1'b1; tick(); pop = 1'b0;
        chk("R10 underrun", 32'(err_flag), 32'd1);
        flush = 1'b1; push = 1'b1; push_data = 32'h1111_2222; tick();
        flush = 1'b0; push = 1'b0;
        chk("R8 push ignored", 32'(empty), 32'd1);
        chk("R8 error kept", 32'(err_flag), 32'd1);

        // R3 push+pop on empty: only push takes effect
        push = 1'b1; pop = 1'b1; push_data = 32'h7777_0001; tick(); idle();
        chk("R3 level", 32'(level_code), 32'd1);
        chk("R3 head", pop_data, 32'h7777_0001);

        // R1 reset mid-run
        push = 1'b1; tick(); push = 1'b0;
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        chk("R1 empty after reset", 32'(empty), 32'd1);
        chk("R1 err after reset", 32'(err_flag), 32'd0);

        finish_run();
    end
endmodule